// File: doc/BRIEF.md
# Multiframe Pulse Generator with Frame-Step Phase Offset

The block builds a 166 Hz multiframe timing mark out of an 8 kHz frame-sync strobe. It counts frame strobes modulo 48, so one multiframe lasts 6 ms. It raises its pulse output for the one whole frame period in which the count matches a programmed offset. The offset moves the mark later in steps of one 125 µs frame, from no shift up to 47 frames.

A byte-wide control register is written and read through a plain write-enable/data port with a continuous readback. Its low six bits hold the offset. The next bit picks the pulse source: the internal counter, or an external 166 Hz pulse from the backplane. The external pulse passes through a two-flop synchroniser and a rising-edge detector before it reaches the output. An active-low mode pin reports which source is in use.

Top module: `mframe_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00, `mode_n` is 1, the frame counter is 0 and the active offset is 0, so `mf_pulse` is 1 in the cycle after reset is released.
- R2: The frame counter advances by one on each clock edge where `fs_tick` is 1, wraps from 47 to 0, and holds between strobes. `mf_pulse` does not change between strobes.
- R3: In internal mode (register bit 6 = 0), with an active offset N from 0 to 47, `mf_pulse` is 1 exactly during the frame period in which the counter equals N. This gives one frame-wide pulse per 48 frames.
- R4: Offset codes 48 to 63 in bits 5:0 are stored and read back as written, but the pulse is placed as if the offset were 0.
- R5: A new offset becomes active only at the clock edge where the counter wraps from 47 to 0. Until that edge the previous offset still places the pulse.
- R6: A write stores data bits 6:0. Bit 7 always reads 0, and writing 1 to it has no effect.
- R7: In external mode (bit 6 = 1), `mode_n` is 0. A rising edge on `ext_mf_in` that is sampled at clock edge k gives `mf_pulse` = 1 for exactly one cycle, between edges k+1 and k+2. A level held high or a falling edge gives no pulse.
- R8: In external mode the internal pulse is suppressed while the counter keeps running. Clearing bit 6 restores the internal pulse immediately and drives `mode_n` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_tick | input | 1 | One-cycle strobe once per 125 µs frame, synchronous to clk |
| ext_mf_in | input | 1 | External 166 Hz pulse from the backplane, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data: [5:0] offset, [6] external mode, [7] ignored |
| reg_rd_data | output | 8 | Register readback |
| mf_pulse | output | 1 | Multiframe pulse output |
| mode_n | output | 1 | Mode pin: 1 = internal source, 0 = external source |

## Verification
Every one of the 64 offset codes is written in turn. Each write lands part-way through a multiframe, and the output is then compared over two full multiframes. The frames before the wrap tell whether the old offset is still in force. The frames after the wrap tell a correct pulse position from an off-by-one error, and reserved codes from legal ones.

Idle cycles between strobes show whether the counter holds. In external mode the bench drives rising edges, held-high levels and falling edges, and runs frames at the same time. This shows whether the edge detector has the right latency and pulse width, and whether the internal pulse leaks into the output. Writes with bit 7 set show that the reserved bit is discarded.

// File: rtl/mframe_pkg.sv
// Shared constants and the control register layout for the multiframe
// pulse generator. Assumes one frame strobe per 125 us.
package mframe_pkg;
    localparam int FRAMES_PER_MF = 48;
    localparam int OFFSET_W      = 6;
    localparam int CTRL_W        = 8;
    localparam int SYNC_STAGES   = 2;

    typedef struct packed {
        logic                rsvd;       // always 0
        logic                ext_mode;   // 1 = external pulse source
        logic [OFFSET_W-1:0] offset;     // phase offset in frames
    } ctrl_t;
endpackage

// File: rtl/mf_ctrl_reg.sv
// Control register: stores bits 6:0 on a write strobe, forces bit 7 to 0.
// Assumes writes are synchronous single-cycle strobes.
module mf_ctrl_reg
    import mframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);
    // Register update on write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= {1'b0, wr_data[CTRL_W-2:0]};
    end

    a_r6_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q[CTRL_W-2:0] == $past(wr_data[CTRL_W-2:0])));
    a_r6_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CTRL_W-1]) |=> (ctrl_q.rsvd == 1'b0));
endmodule

// File: rtl/mf_frame_counter.sv
// Frame counter modulo FRAMES and internal pulse placement.
// The requested offset is latched only at the counter wrap. Codes at or
// above FRAMES count as offset 0. Assumes fs_tick is a one-cycle strobe.
module mf_frame_counter #(
    parameter int FRAMES = 48,
    parameter int OFF_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_tick,
    input  logic [OFF_W-1:0] offset_req,
    output logic             mf_int
);
    localparam int CNT_W = $clog2(FRAMES);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] off_act_q;
    logic [CNT_W-1:0] off_eff;
    logic             wrap;

    // Wrap happens on the strobe that closes the last frame.
    assign wrap = fs_tick && (cnt_q == CNT_W'(FRAMES - 1));

    // Map reserved offset codes to zero.
    always_comb begin
        if (offset_req < OFF_W'(FRAMES))
            off_eff = CNT_W'(offset_req);
        else
            off_eff = '0;
    end

    // Frame count: advance on each strobe, wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (fs_tick)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // Active offset: take the requested one only at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_act_q <= '0;
        else if (wrap)
            off_act_q <= off_eff;
    end

    assign mf_int = (cnt_q == off_act_q);

    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(FRAMES));
    a_r2_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_tick |=> $stable(cnt_q));
    a_r2_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_tick && cnt_q == CNT_W'(FRAMES - 1)) |=> (cnt_q == '0));
    a_r5_offset_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(fs_tick && cnt_q == CNT_W'(FRAMES - 1)) |=> $stable(off_act_q));
    a_r4_offset_legal: assert property (@(posedge clk) disable iff (!rst_n)
        off_act_q < CNT_W'(FRAMES));
endmodule

// File: rtl/mf_ext_sync.sv
// Synchroniser chain plus rising-edge detector for the external pulse.
// Assumes the external pulse stays high longer than one clock period.
module mf_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the asynchronous input through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[STAGES-2:0], ext_in};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else
            last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

    a_r7_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mframe_pulse_gen.sv
// Top level: control register, frame counter and external synchroniser.
// Selects the pulse source and drives the active-low mode pin.
// Assumes fs_tick is synchronous to clk.
module mframe_pulse_gen
    import mframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_tick,
    input  logic              ext_mf_in,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wr_data,
    output logic [CTRL_W-1:0] reg_rd_data,
    output logic              mf_pulse,
    output logic              mode_n
);
    ctrl_t ctrl;
    logic  mf_int;
    logic  ext_rise;

    mf_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .ctrl_q  (ctrl)
    );

    mf_frame_counter #(
        .FRAMES (FRAMES_PER_MF),
        .OFF_W  (OFFSET_W)
    ) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_tick    (fs_tick),
        .offset_req (ctrl.offset),
        .mf_int     (mf_int)
    );

    mf_ext_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_mf_in),
        .rise   (ext_rise)
    );

    // Source select and mode pin.
    assign reg_rd_data = ctrl;
    assign mf_pulse    = ctrl.ext_mode ? ext_rise : mf_int;
    assign mode_n      = ~ctrl.ext_mode;

    a_r7_ext_pulse_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_n && mf_pulse) |=> (!mf_pulse || mode_n));
    a_r8_ext_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_n && mf_pulse) |-> ext_rise);
endmodule

// File: tb/test_mframe_pulse_gen.sv
`timescale 1ns/1ps
module test_mframe_pulse_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs_tick = 1'b0;
    logic       ext_mf_in = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       mf_pulse;
    logic       mode_n;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    int m_act = 0;
    logic [7:0] m_reg = 8'h00;

    always #2.5 clk = ~clk;

    mframe_pulse_gen i_mframe_pulse_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_tick     (fs_tick),
        .ext_mf_in   (ext_mf_in),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .mf_pulse    (mf_pulse),
        .mode_n      (mode_n)
    );

    function automatic int eff_off(input logic [7:0] r);
        return (int'(r[5:0]) >= 48) ? 0 : int'(r[5:0]);
    endfunction

    function automatic logic exp_pulse();
        return m_reg[6] ? 1'b0 : (m_cnt == m_act);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cnt=%0d)", tag, act, exp, m_cnt);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        m_reg       = {1'b0, d[6:0]};
    endtask

    // One frame: strobe, then idle cycles; checks placement and hold.
    task automatic frame(input string tag);
        @(negedge clk);
        fs_tick = 1'b1;
        @(negedge clk);
        fs_tick = 1'b0;
        if (m_cnt == 47) begin
            m_cnt = 0;
            m_act = eff_off(m_reg);
        end else begin
            m_cnt++;
        end
        chk(tag, {7'd0, mf_pulse}, {7'd0, exp_pulse()});
        repeat (2) begin
            @(negedge clk);
            chk("R2 hold between strobes", {7'd0, mf_pulse}, {7'd0, exp_pulse()});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 readback", reg_rd_data, 8'h00);
        chk("R1 mode_n", {7'd0, mode_n}, 8'h01);
        chk("R1 pulse at count 0", {7'd0, mf_pulse}, 8'h01);

        repeat (5) frame("R2 advance");

        // R3/R4/R5: sweep all offset codes, writes land mid-multiframe
        for (int off = 0; off < 64; off++) begin
            wr(8'(off));
            chk(off >= 48 ? "R4 reserved readback" : "R6 readback", reg_rd_data, 8'(off));
            for (int f = 0; f < 96; f++) begin
                string tag;
                if (f < 43)       tag = "R5 old offset before wrap";
                else if (off >= 48) tag = "R4 reserved acts as 0";
                else              tag = "R3 pulse placement";
                frame(tag);
            end
        end

        // R7: external mode
        wr(8'h45);
        chk("R7 mode_n low", {7'd0, mode_n}, 8'h00);
        chk("R6 readback ext", reg_rd_data, 8'h45);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); ext_mf_in = 1'b1;
            @(negedge clk); chk("R7 sync latency", {7'd0, mf_pulse}, 8'h00);
            @(negedge clk); chk("R7 edge pulse", {7'd0, mf_pulse}, 8'h01);
            @(negedge clk); chk("R7 one cycle wide", {7'd0, mf_pulse}, 8'h00);
            repeat (3) begin
                @(negedge clk); chk("R7 high level no pulse", {7'd0, mf_pulse}, 8'h00);
            end
            ext_mf_in = 1'b0;
            repeat (4) begin
                @(negedge clk); chk("R7 falling edge no pulse", {7'd0, mf_pulse}, 8'h00);
            end
        end
        // R8: internal pulse suppressed while the counter keeps running
        repeat (50) frame("R8 internal suppressed");

        wr(8'h05);
        chk("R8 mode_n high", {7'd0, mode_n}, 8'h01);
        chk("R8 pulse restored", {7'd0, mf_pulse}, {7'd0, exp_pulse()});
        repeat (48) frame("R8 internal restored");

        // R6: bit 7 ignored
        wr(8'hFF);
        chk("R6 bit7 dropped", reg_rd_data, 8'h7F);
        chk("R7 mode_n low", {7'd0, mode_n}, 8'h00);
        wr(8'h80);
        chk("R6 bit7 only", reg_rd_data, 8'h00);
        chk("R8 mode_n high", {7'd0, mode_n}, 8'h01);
        repeat (96) frame("R4 reserved then zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule